// File: doc/BRIEF.md
# Immediate Prefix Fusion Unit

This decode-stage unit lets an instruction set carry wide literals in separate prefix instructions, so the instructions that use them do not need immediate fields. Each prefix holds a literal of 16, 32 or 64 bits and selects sign or zero extension. The unit extends the literal to the datapath width and places it in one of two constant slots kept inside the decoder. The first prefix of a group uses slot 0 and the second uses slot 1.

The next non-prefix instruction (the consumer) states how many constants it takes, from zero to two. The unit then issues one fused operation that carries the consumer's opcode and the stashed constants. The fused operation takes the address of the first prefix in the group. A fault on the group therefore points back at the start of the group, and no constant state has to be saved or restored across it.

When a sequence is malformed, the unit reports a fault code together with the address where execution would restart. A flush, a fault or an issued consumer empties both slots.

Top module: `imm_fuse_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `fused_valid` and `fault_valid` are low and both constant slots are empty.
- R2: The prefix size code is 0 for 16 bits, 1 for 32 bits and 2 for 64 bits, taken from the low bits of `pfx_literal`. With `pfx_signed`=1 the top kept bit is copied into the upper bits. With `pfx_signed`=0 the upper bits are zero.
- R3: The first prefix of a group fills slot 0 and the second fills slot 1. A consumer gets slot 0 on `fused_imm0` and slot 1 on `fused_imm1`. Any immediate it does not use reads zero.
- R4: A well-formed consumer produces `fused_valid` on the clock edge that samples it, with its `cons_op`. `fused_pc` is the address of the first prefix of the group, or the consumer's own address when it takes no constant.
- R5: A prefix that arrives while both slots are full raises fault code 1 (bad sequence), with `fault_pc` set to the first prefix of the group.
- R6: A consumer whose `cons_need` is 3, or is larger than the number of filled slots, raises fault code 2 (missing constant). `fault_pc` is the first prefix of the group, or the consumer's own address when no slot is filled.
- R7: A consumer that uses fewer constants than are stashed raises fault code 1, with `fault_pc` set to the first prefix.
- R8: A prefix with size code 3 raises fault code 3 (bad size), with `fault_pc` set to the start of the group.
- R9: `flush` empties both slots and produces no output, even when it comes together with a valid instruction.
- R10: After any fault or issued consumer, both slots are empty. `fused_valid` and `fault_valid` are never high together.
- R11: Cycles with `in_valid` low leave the stashed constants unchanged and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard stashed constants |
| in_valid | input | 1 | A decoded instruction is present |
| in_is_prefix | input | 1 | The instruction is an immediate prefix |
| in_pc | input | PC_W | Address of the instruction |
| pfx_size | input | 2 | Literal size code (0:16, 1:32, 2:64, 3:illegal) |
| pfx_signed | input | 1 | 1 = sign extend, 0 = zero extend |
| pfx_literal | input | DATA_W | Raw literal bits |
| cons_op | input | OP_W | Consumer opcode |
| cons_need | input | 2 | Number of constants the consumer uses |
| fused_valid | output | 1 | Fused operation issued |
| fused_op | output | OP_W | Opcode of the fused operation |
| fused_pc | output | PC_W | Address of the group start |
| fused_imm0 | output | DATA_W | First constant |
| fused_imm1 | output | DATA_W | Second constant |
| fault_valid | output | 1 | Fault reported |
| fault_code | output | 2 | 1 bad sequence, 2 missing constant, 3 bad size |
| fault_pc | output | PC_W | Restart address |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath, 32-bit addresses and 8-bit opcodes. With a 64-bit datapath all three literal sizes can be tested, including the 64-bit case where no extension takes place, and the sign bit can be set at each kept width. Two slots are enough to reach every ordering fault: a third prefix, too few constants and too many constants. Directed sequences also cover idle gaps, flush together with a prefix, and restart after each fault.

// File: rtl/imm_fuse_pkg.sv
// Shared encodings for the immediate prefix fusion unit.
package imm_fuse_pkg;
    typedef enum logic [1:0] {
        SZ_16  = 2'd0,
        SZ_32  = 2'd1,
        SZ_64  = 2'd2,
        SZ_BAD = 2'd3
    } imm_size_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_SEQ     = 2'd1,
        FLT_MISSING = 2'd2,
        FLT_SIZE    = 2'd3
    } fault_e;

    localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/imm_extender.sv
// Extends a raw literal to DATA_W bits, keeping 16, 32 or 64 low bits.
// Assumes DATA_W >= 64. Size code 3 yields the 64-bit form; the controller
// rejects it separately.
module imm_extender #(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        size,
    input  logic              signed_en,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] ext
);
    logic [DATA_W-1:0] cand [3];

    for (genvar g = 0; g < 3; g++) begin : g_width
        localparam int KB = 16 << g;
        if (KB >= DATA_W) begin : g_full
            assign cand[g] = raw;
        end else begin : g_part
            assign cand[g] = {{(DATA_W-KB){signed_en & raw[KB-1]}}, raw[KB-1:0]};
        end
    end

    // Select the candidate for the requested literal size.
    always_comb begin
        case (size)
            2'd0:    ext = cand[0];
            2'd1:    ext = cand[1];
            default: ext = cand[2];
        endcase
    end
endmodule

// File: rtl/creg_bank.sv
// Two decoder-local constant slots, each with a valid bit, and the address
// of the prefix that opened the group. Slots fill in order. The writer must
// not write while both are full.
module creg_bank #(
    parameter int DATA_W = 64,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PC_W-1:0]   wr_pc,
    output logic [1:0]        cval,
    output logic [DATA_W-1:0] creg [2],
    output logic [PC_W-1:0]   grp_pc
);
    logic wr_slot;
    assign wr_slot = cval[0];

    for (genvar s = 0; s < 2; s++) begin : g_slot
        // Load the slot when it is next in order; drop it on clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cval[s] <= 1'b0;
                creg[s] <= '0;
            end else if (clear) begin
                cval[s] <= 1'b0;
            end else if (wr_en && (wr_slot == 1'(s))) begin
                cval[s] <= 1'b1;
                creg[s] <= wr_data;
            end
        end
    end

    // Remember the address of the first prefix in the group.
    always_ff @(posedge clk) begin
        if (!rst_n)                  grp_pc <= '0;
        else if (wr_en && !cval[0])  grp_pc <= wr_pc;
    end
endmodule

// File: rtl/fuse_ctrl.sv
// Combinational sequencing for one decoded instruction per cycle. It decides
// whether to stash, fuse or fault, and which address to report.
module fuse_ctrl
    import imm_fuse_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            flush,
    input  logic            in_valid,
    input  logic            in_is_prefix,
    input  logic [1:0]      pfx_size,
    input  logic [1:0]      cons_need,
    input  logic [PC_W-1:0] in_pc,
    input  logic [1:0]      cval,
    input  logic [PC_W-1:0] grp_pc,
    output logic            wr_en,
    output logic            clear,
    output logic            emit_fused,
    output logic            emit_fault,
    output fault_e          fcode,
    output logic [PC_W-1:0] rep_pc
);
    logic [1:0] nfill;
    assign nfill = {1'b0, cval[0]} + {1'b0, cval[1]};

    // Classify the current slot and choose the action.
    always_comb begin
        wr_en      = 1'b0;
        clear      = 1'b0;
        emit_fused = 1'b0;
        emit_fault = 1'b0;
        fcode      = FLT_NONE;
        rep_pc     = cval[0] ? grp_pc : in_pc;
        if (flush) begin
            clear = 1'b1;
        end else if (in_valid) begin
            if (in_is_prefix) begin
                if (imm_size_e'(pfx_size) == SZ_BAD) begin
                    emit_fault = 1'b1;
                    fcode      = FLT_SIZE;
                    clear      = 1'b1;
                end else if (cval[1]) begin
                    emit_fault = 1'b1;
                    fcode      = FLT_SEQ;
                    clear      = 1'b1;
                end else begin
                    wr_en = 1'b1;
                end
            end else begin
                clear = 1'b1;
                if (cons_need == 2'd3 || cons_need > nfill) begin
                    emit_fault = 1'b1;
                    fcode      = FLT_MISSING;
                end else if (cons_need < nfill) begin
                    emit_fault = 1'b1;
                    fcode      = FLT_SEQ;
                end else begin
                    emit_fused = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/imm_fuse_unit.sv
// Top of the immediate prefix fusion unit. Prefixes stash extended literals
// in two slots. The next consumer issues as one fused operation at the
// group's first address, or faults. Outputs are registered and change on
// the edge that samples the instruction.
module imm_fuse_unit
    import imm_fuse_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PC_W   = 32,
    parameter int OP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic              in_is_prefix,
    input  logic [PC_W-1:0]   in_pc,
    input  logic [1:0]        pfx_size,
    input  logic              pfx_signed,
    input  logic [DATA_W-1:0] pfx_literal,
    input  logic [OP_W-1:0]   cons_op,
    input  logic [1:0]        cons_need,
    output logic              fused_valid,
    output logic [OP_W-1:0]   fused_op,
    output logic [PC_W-1:0]   fused_pc,
    output logic [DATA_W-1:0] fused_imm0,
    output logic [DATA_W-1:0] fused_imm1,
    output logic              fault_valid,
    output logic [1:0]        fault_code,
    output logic [PC_W-1:0]   fault_pc
);
    logic [DATA_W-1:0] ext_val;
    logic [1:0]        cval;
    logic [DATA_W-1:0] creg [2];
    logic [PC_W-1:0]   grp_pc;
    logic              wr_en, clear, emit_fused, emit_fault;
    fault_e            fcode;
    logic [PC_W-1:0]   rep_pc;

    imm_extender #(.DATA_W(DATA_W)) u_ext (
        .size(pfx_size), .signed_en(pfx_signed), .raw(pfx_literal), .ext(ext_val)
    );

    creg_bank #(.DATA_W(DATA_W), .PC_W(PC_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en),
        .wr_data(ext_val), .wr_pc(in_pc), .cval(cval), .creg(creg), .grp_pc(grp_pc)
    );

    fuse_ctrl #(.PC_W(PC_W)) u_ctrl (
        .flush(flush), .in_valid(in_valid), .in_is_prefix(in_is_prefix),
        .pfx_size(pfx_size), .cons_need(cons_need), .in_pc(in_pc),
        .cval(cval), .grp_pc(grp_pc), .wr_en(wr_en), .clear(clear),
        .emit_fused(emit_fused), .emit_fault(emit_fault), .fcode(fcode), .rep_pc(rep_pc)
    );

    // Register the fused operation and its immediates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fused_valid <= 1'b0;
            fused_op    <= '0;
            fused_pc    <= '0;
            fused_imm0  <= '0;
            fused_imm1  <= '0;
        end else begin
            fused_valid <= emit_fused;
            if (emit_fused) begin
                fused_op   <= cons_op;
                fused_pc   <= rep_pc;
                fused_imm0 <= (cons_need >= 2'd1) ? creg[0] : '0;
                fused_imm1 <= (cons_need == 2'd2) ? creg[1] : '0;
            end
        end
    end

    // Register the fault report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_valid <= 1'b0;
            fault_code  <= 2'd0;
            fault_pc    <= '0;
        end else begin
            fault_valid <= emit_fault;
            if (emit_fault) begin
                fault_code <= fcode;
                fault_pc   <= rep_pc;
            end
        end
    end
endmodule

// File: rtl/imm_fuse_chk.sv
// Protocol checks for imm_fuse_unit, attached by bind.
module imm_fuse_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flush,
    input logic       in_valid,
    input logic       in_is_prefix,
    input logic [1:0] cval,
    input logic       fused_valid,
    input logic       fault_valid,
    input logic [1:0] fault_code
);
    // R10
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fused_valid && fault_valid));

    // R3
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cval[1] |-> cval[0]);

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cval == 2'b00) && !fused_valid && !fault_valid);

    // R4
    fused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_is_prefix && !flush) |=> (fused_valid || fault_valid));

    // R5
    third_pfx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_prefix && !flush && cval == 2'b11)
            |=> fault_valid && fault_code != 2'd2 && fault_code != 2'd0);

    // R10
    empty_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fused_valid || fault_valid) |-> cval == 2'b00);
endmodule

bind imm_fuse_unit imm_fuse_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_is_prefix(in_is_prefix), .cval(cval), .fused_valid(fused_valid),
    .fault_valid(fault_valid), .fault_code(fault_code)
);

// File: tb/tb_imm_fuse_unit.sv
`timescale 1ns/1ps
module tb_imm_fuse_unit;
    logic        clk = 1'b0;
    logic        rst_n, flush, in_valid, in_is_prefix, pfx_signed;
    logic [31:0] in_pc;
    logic [1:0]  pfx_size, cons_need;
    logic [63:0] pfx_literal;
    logic [7:0]  cons_op;
    logic        fused_valid, fault_valid;
    logic [7:0]  fused_op;
    logic [31:0] fused_pc, fault_pc;
    logic [63:0] fused_imm0, fused_imm1;
    logic [1:0]  fault_code;
    int errors = 0, checks = 0, cyc = 0;

    always #10 clk = ~clk;

    imm_fuse_unit dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_is_prefix(in_is_prefix), .in_pc(in_pc), .pfx_size(pfx_size),
        .pfx_signed(pfx_signed), .pfx_literal(pfx_literal), .cons_op(cons_op),
        .cons_need(cons_need), .fused_valid(fused_valid), .fused_op(fused_op),
        .fused_pc(fused_pc), .fused_imm0(fused_imm0), .fused_imm1(fused_imm1),
        .fault_valid(fault_valid), .fault_code(fault_code), .fault_pc(fault_pc)
    );

    // {size, signed, literal, expected}
    localparam logic [130:0] VEC [8] = '{
        {2'd0, 1'b1, 64'hDEAD_BEEF_1234_8001, 64'hFFFF_FFFF_FFFF_8001},
        {2'd0, 1'b0, 64'hDEAD_BEEF_1234_8001, 64'h0000_0000_0000_8001},
        {2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_7FFE, 64'h0000_0000_0000_7FFE},
        {2'd1, 1'b1, 64'h0123_4567_8000_0000, 64'hFFFF_FFFF_8000_0000},
        {2'd1, 1'b0, 64'h0123_4567_8000_0000, 64'h0000_0000_8000_0000},
        {2'd1, 1'b1, 64'hAAAA_AAAA_1234_5678, 64'h0000_0000_1234_5678},
        {2'd2, 1'b0, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001},
        {2'd2, 1'b1, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        in_valid = 0; in_is_prefix = 0; flush = 0; cons_need = 0;
    endtask

    task automatic pfx(input logic [31:0] pc, input logic [1:0] sz, input logic sg,
                       input logic [63:0] lit);
        @(negedge clk);
        idle_in();
        in_valid = 1; in_is_prefix = 1; in_pc = pc;
        pfx_size = sz; pfx_signed = sg; pfx_literal = lit;
        @(posedge clk); #1;
    endtask

    task automatic cons(input logic [31:0] pc, input logic [7:0] op, input logic [1:0] need);
        @(negedge clk);
        idle_in();
        in_valid = 1; in_pc = pc; cons_op = op; cons_need = need;
        @(posedge clk); #1;
    endtask

    task automatic idle();
        @(negedge clk);
        idle_in();
        @(posedge clk); #1;
    endtask

    task automatic expect_fault(input string req, input logic [1:0] code, input logic [31:0] pc);
        chk(req, {63'd0, fault_valid}, 64'd1);
        chk(req, {63'd0, fused_valid}, 64'd0);
        chk(req, {62'd0, fault_code}, {62'd0, code});
        chk(req, {32'd0, fault_pc}, {32'd0, pc});
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle_in(); in_pc = 0; pfx_size = 0; pfx_signed = 0;
        pfx_literal = 0; cons_op = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs low during reset
        chk("R1", {62'd0, fused_valid, fault_valid}, 64'd0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        chk("R1", {62'd0, fused_valid, fault_valid}, 64'd0);
        // R1: slots empty: consumer needing one constant faults
        cons(32'h50, 8'h01, 2'd1);
        expect_fault("R1", 2'd2, 32'h50);

        // R2 R4: extension table
        for (int i = 0; i < 8; i++) begin
            logic [31:0] pc;
            pc = 32'h1000 + 32'(i * 16);
            pfx(pc, VEC[i][130:129], VEC[i][128], VEC[i][127:64]);
            chk("R4", {62'd0, fused_valid, fault_valid}, 64'd0);
            cons(pc + 4, 8'(8'h10 + i), 2'd1);
            chk("R4", {63'd0, fused_valid}, 64'd1);
            chk("R2", fused_imm0, VEC[i][63:0]);
            chk("R3", fused_imm1, 64'd0);
            chk("R4", {32'd0, fused_pc}, {32'd0, pc});
            chk("R4", {56'd0, fused_op}, {56'd0, 8'(8'h10 + i)});
        end

        // R3 R11: two prefixes with idle gaps, consumer uses both
        pfx(32'h2000, 2'd1, 1'b0, 64'h1111_2222);
        idle();
        chk("R11", {62'd0, fused_valid, fault_valid}, 64'd0);
        pfx(32'h2004, 2'd0, 1'b1, 64'hFFFE);
        idle(); idle();
        cons(32'h2008, 8'h42, 2'd2);
        chk("R3", fused_imm0, 64'h1111_2222);
        chk("R3", fused_imm1, 64'hFFFF_FFFF_FFFF_FFFE);
        chk("R4", {32'd0, fused_pc}, 64'h2000);

        // R4: consumer without constants reports its own address
        cons(32'h2100, 8'h07, 2'd0);
        chk("R4", {63'd0, fused_valid}, 64'd1);
        chk("R4", {32'd0, fused_pc}, 64'h2100);
        chk("R3", fused_imm0, 64'd0);

        // R10: slots emptied after the consumer
        cons(32'h2104, 8'h08, 2'd1);
        expect_fault("R10", 2'd2, 32'h2104);

        // R5: third prefix
        pfx(32'h3000, 2'd0, 1'b0, 64'h1);
        pfx(32'h3004, 2'd0, 1'b0, 64'h2);
        pfx(32'h3008, 2'd0, 1'b0, 64'h3);
        expect_fault("R5", 2'd1, 32'h3000);
        cons(32'h300C, 8'h09, 2'd0);
        chk("R10", {63'd0, fused_valid}, 64'd1);
        chk("R10", {32'd0, fused_pc}, 64'h300C);

        // R6: one prefix, consumer needs two
        pfx(32'h4000, 2'd0, 1'b0, 64'h5);
        cons(32'h4004, 8'h0A, 2'd2);
        expect_fault("R6", 2'd2, 32'h4000);
        // R6: need code 3
        pfx(32'h4100, 2'd0, 1'b0, 64'h5);
        pfx(32'h4104, 2'd0, 1'b0, 64'h6);
        cons(32'h4108, 8'h0B, 2'd3);
        expect_fault("R6", 2'd2, 32'h4100);

        // R7: two prefixes, consumer uses one
        pfx(32'h5000, 2'd1, 1'b0, 64'h7);
        pfx(32'h5004, 2'd1, 1'b0, 64'h8);
        cons(32'h5008, 8'h0C, 2'd1);
        expect_fault("R7", 2'd1, 32'h5000);

        // R8: bad size code as second prefix, then as first
        pfx(32'h6000, 2'd0, 1'b0, 64'h9);
        pfx(32'h6004, 2'd3, 1'b0, 64'hA);
        expect_fault("R8", 2'd3, 32'h6000);
        pfx(32'h6100, 2'd3, 1'b0, 64'hA);
        expect_fault("R8", 2'd3, 32'h6100);
        cons(32'h6104, 8'h0D, 2'd0);
        chk("R8", {32'd0, fused_pc}, 64'h6104);

        // R9: flush empties slots, and wins over a prefix in the same cycle
        pfx(32'h7000, 2'd0, 1'b0, 64'hB);
        @(negedge clk);
        idle_in(); flush = 1; in_valid = 1; in_is_prefix = 1; in_pc = 32'h7004;
        @(posedge clk); #1;
        chk("R9", {62'd0, fused_valid, fault_valid}, 64'd0);
        cons(32'h7008, 8'h0E, 2'd1);
        expect_fault("R9", 2'd2, 32'h7008);

        idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule